// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM device from the end of system reset to an operational state. It holds the clock-enable pin low through the long power-up settling time, raises it, waits a short fraction of that time, then plays out the fixed list of precharge, mode-load and refresh commands the device needs. The list includes programming the extended mode registers, resetting and enabling the on-die DLL, and setting the output-driver impedance to its default. Every delay is counted in clock cycles derived from a clock-frequency parameter, and a short-simulation mode replaces the long settling time with a small cycle count.

After the last command the sequencer asks a separate calibration stage to run, using a request/acknowledge pair. It raises its init-done output only once that stage acknowledges. Between commands it drives a no-operation code. The spacing between commands comes from one down-counter that is reloaded with the recovery time of the command just sent.

Top module: `ddr2init_seq`

## Requirements
- R1: A synchronous reset, at any point, returns the block to its start: cke low, cmdCode NOP, bank and addr zero, calReq low, initDone low, and the whole sequence restarts after reset is released.
- R2: cke goes high on the PWR-th rising edge after reset is released, where PWR is 200 times CLK_MHZ, or SIM_PWR_CYC when SHORT_SIM is set.
- R3: The first command appears POST cycles after cke rises, with POST equal to PWR divided by 500 and never less than 1.
- R4: cmdCode carries {cs_n, ras_n, cas_n, we_n}: NOP 4'b0111, precharge 4'b0010, mode load 4'b0000, refresh 4'b0001; between commands it is NOP with bank and addr zero.
- R5: Commands come in this order: precharge-all; mode load to bank 2 with addr 0; mode load to bank 3 with addr 0; mode load to bank 1 with EMR1_VALUE bit 0 cleared (DLL on); mode load to bank 0 with MR_VALUE and addr bit 8 set (DLL reset); precharge-all; refresh; refresh; mode load to bank 0 with MR_VALUE and addr bit 8 cleared; two loads to bank 1 as in R8.
- R6: Each precharge-all uses bank 0 and addr with only bit AP_BIT high.
- R7: The next command follows a precharge by exactly T_RP cycles, a mode load by exactly T_MRD cycles and a refresh by exactly T_RFC cycles, except where R8 adds delay.
- R8: The first bank-1 load after the final mode load is issued at the later of T_MRD cycles after that load and DLL_WAIT cycles after the DLL-reset load; it has addr bits 9:7 set to 3'b111 (driver default). The second follows T_MRD later with addr bits 9:7 cleared (exit), and ends the command list.
- R9: calReq rises T_MRD cycles after the last command, stays high until calAck is seen, and no command is issued while it is high.
- R10: One cycle after calAck is seen high with calReq high, calReq falls and initDone rises; initDone then stays high until reset.
- R11: calAck has no effect while calReq is low: initDone stays low and the sequence timing is unchanged.
- R12: Once raised, cke stays high until reset, and no command other than NOP is issued while cke is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| calAck | input | 1 | Calibration stage reports completion |
| cke | output | 1 | Memory clock enable |
| cmdCode | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| bank | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address |
| calReq | output | 1 | Request to the calibration stage |
| initDone | output | 1 | Initialization and calibration complete |

## Verification
The command list is compared entry by entry against a table of expected code, bank, address and issue cycle, so an error in ordering, a mode value or any single gap shows up as a distinct row. The recovery times are chosen unequal so that swapping the precharge, mode-load and refresh spacings changes the cycle numbers, and the driver-default load is placed where the DLL wait dominates, telling it apart from a plain T_MRD gap. A second instance with a short power-up count checks the one-cycle floor of the post-cke wait. Acknowledge pulses during power-up and mid-sequence show that early acknowledges are ignored, and resets during the command stream and after completion show a full restart.

// File: rtl/ddr2init_pkg.sv
package ddr2init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_SEQ   = 2'd1,
    PH_CAL   = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_PRE1   = 4'd0;
  localparam logic [STEP_W-1:0] STEP_EMR2   = 4'd1;
  localparam logic [STEP_W-1:0] STEP_EMR3   = 4'd2;
  localparam logic [STEP_W-1:0] STEP_EMR1   = 4'd3;
  localparam logic [STEP_W-1:0] STEP_MRRST  = 4'd4;
  localparam logic [STEP_W-1:0] STEP_PRE2   = 4'd5;
  localparam logic [STEP_W-1:0] STEP_REF1   = 4'd6;
  localparam logic [STEP_W-1:0] STEP_REF2   = 4'd7;
  localparam logic [STEP_W-1:0] STEP_MRRUN  = 4'd8;
  localparam logic [STEP_W-1:0] STEP_OCDDEF = 4'd9;
  localparam logic [STEP_W-1:0] STEP_OCDEXT = 4'd10;
  localparam logic [STEP_W-1:0] STEP_END    = 4'd11;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic              ckeOn;
    logic              issue;
    logic [STEP_W-1:0] step;
    logic              calSet;
    logic              doneSet;
  } seqStrobe_t;

endpackage

// File: rtl/ddr2init_ctrl.sv
module ddr2init_ctrl
  import ddr2init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       waitZero,
  input  logic       dllReady,
  input  logic       calAck,
  output seqStrobe_t strb
);

  phase_t            phase, phaseNext;
  logic [STEP_W-1:0] step, stepNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_PWRUP;
      step  <= STEP_PRE1;
    end else begin
      phase <= phaseNext;
      step  <= stepNext;
    end
  end

  always_comb begin
    phaseNext    = phase;
    stepNext     = step;
    strb         = '0;
    strb.step    = step;
    unique case (phase)
      PH_PWRUP: begin
        if (waitZero) begin
          strb.ckeOn = 1'b1;
          phaseNext  = PH_SEQ;
          stepNext   = STEP_PRE1;
        end
      end
      PH_SEQ: begin
        if (step == STEP_END) begin
          if (waitZero) begin
            strb.calSet = 1'b1;
            phaseNext   = PH_CAL;
          end
        end else if (waitZero && (step != STEP_OCDDEF || dllReady)) begin
          strb.issue = 1'b1;
          stepNext   = step + 1'b1;
        end
      end
      PH_CAL: begin
        if (calAck) begin
          strb.doneSet = 1'b1;
          phaseNext    = PH_DONE;
        end
      end
      PH_DONE: begin
        phaseNext = PH_DONE;
      end
      default: phaseNext = PH_PWRUP;
    endcase
  end

endmodule

// File: rtl/ddr2init_dpath.sv
module ddr2init_dpath
  import ddr2init_pkg::*;
#(
  parameter int          PWR_CYC    = 25000,
  parameter int          POST_CYC   = 50,
  parameter int          CNT_W      = 15,
  parameter int          T_MRD      = 2,
  parameter int          T_RP       = 3,
  parameter int          T_RFC      = 16,
  parameter int          DLL_WAIT   = 200,
  parameter int          ADDR_W     = 14,
  parameter int          BA_W       = 3,
  parameter int          AP_BIT     = 10,
  parameter int unsigned MR_VALUE   = 'h0242,
  parameter int unsigned EMR1_VALUE = 'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  output logic              waitZero,
  output logic              dllReady,
  output logic              cke,
  output logic [3:0]        cmdCode,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              calReq,
  output logic              initDone
);

  localparam int DLL_W = $clog2(DLL_WAIT + 1);

  localparam logic [ADDR_W-1:0] DLLRST_BIT = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] OCD_FIELD  = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] ALLBANKS   = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MR_RUN     = ADDR_W'(MR_VALUE) & ~DLLRST_BIT;
  localparam logic [ADDR_W-1:0] MR_RESET   = MR_RUN | DLLRST_BIT;
  localparam logic [ADDR_W-1:0] EMR1_ON    = ADDR_W'(EMR1_VALUE) & ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] EMR1_OCD   = EMR1_ON | OCD_FIELD;
  localparam logic [ADDR_W-1:0] EMR1_EXIT  = EMR1_ON & ~OCD_FIELD;

  localparam logic [CNT_W-1:0] GAP_MRD  = CNT_W'(T_MRD);
  localparam logic [CNT_W-1:0] GAP_RP   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] GAP_RFC  = CNT_W'(T_RFC);
  localparam logic [DLL_W-1:0] DLL_LAST = DLL_W'(DLL_WAIT - 1);

  cmd_t              stepCmd;
  logic [BA_W-1:0]   stepBank;
  logic [ADDR_W-1:0] stepAddr;
  logic [CNT_W-1:0]  stepGap;

  logic [CNT_W-1:0]  waitCnt;
  logic [DLL_W-1:0]  dllCnt;
  logic              dllRun;

  // Command contents for each step of the list.
  always_comb begin
    stepCmd  = CMD_MRS;
    stepBank = '0;
    stepAddr = '0;
    stepGap  = GAP_MRD;
    unique case (strb.step)
      STEP_PRE1, STEP_PRE2: begin
        stepCmd  = CMD_PRE;
        stepAddr = ALLBANKS;
        stepGap  = GAP_RP;
      end
      STEP_EMR2:   stepBank = BA_W'(2);
      STEP_EMR3:   stepBank = BA_W'(3);
      STEP_EMR1: begin
        stepBank = BA_W'(1);
        stepAddr = EMR1_ON;
      end
      STEP_MRRST:  stepAddr = MR_RESET;
      STEP_REF1, STEP_REF2: begin
        stepCmd = CMD_REF;
        stepGap = GAP_RFC;
      end
      STEP_MRRUN:  stepAddr = MR_RUN;
      STEP_OCDDEF: begin
        stepBank = BA_W'(1);
        stepAddr = EMR1_OCD;
      end
      STEP_OCDEXT: begin
        stepBank = BA_W'(1);
        stepAddr = EMR1_EXIT;
      end
      default: stepCmd = CMD_NOP;
    endcase
  end

  // Single reusable down-counter: power-up, post-CKE wait and command gaps.
  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt <= CNT_W'(PWR_CYC - 1);
    end else if (strb.ckeOn) begin
      waitCnt <= CNT_W'(POST_CYC - 1);
    end else if (strb.issue) begin
      waitCnt <= stepGap - CNT_W'(1);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign waitZero = (waitCnt == '0);

  // Elapsed-cycle counter started by the DLL-reset mode load.
  always_ff @(posedge clk) begin
    if (rst) begin
      dllRun <= 1'b0;
      dllCnt <= '0;
    end else if (strb.issue && strb.step == STEP_MRRST) begin
      dllRun <= 1'b1;
      dllCnt <= '0;
    end else if (dllRun && dllCnt != DLL_LAST) begin
      dllCnt <= dllCnt + DLL_W'(1);
    end
  end

  assign dllReady = dllRun && (dllCnt == DLL_LAST);

  // Registered pin drivers.
  always_ff @(posedge clk) begin
    if (rst) begin
      cke      <= 1'b0;
      cmdCode  <= CMD_NOP;
      bank     <= '0;
      addr     <= '0;
      calReq   <= 1'b0;
      initDone <= 1'b0;
    end else begin
      if (strb.ckeOn) cke <= 1'b1;
      if (strb.issue) begin
        cmdCode <= stepCmd;
        bank    <= stepBank;
        addr    <= stepAddr;
      end else begin
        cmdCode <= CMD_NOP;
        bank    <= '0;
        addr    <= '0;
      end
      if (strb.calSet) calReq <= 1'b1;
      else if (strb.doneSet) calReq <= 1'b0;
      if (strb.doneSet) initDone <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr2init_seq.sv
module ddr2init_seq
  import ddr2init_pkg::*;
#(
  parameter int          CLK_MHZ     = 125,
  parameter bit          SHORT_SIM   = 1'b0,
  parameter int          SIM_PWR_CYC = 1000,
  parameter int          T_MRD       = 2,
  parameter int          T_RP        = 3,
  parameter int          T_RFC       = 16,
  parameter int          DLL_WAIT    = 200,
  parameter int          ADDR_W      = 14,
  parameter int          BA_W        = 3,
  parameter int          AP_BIT      = 10,
  parameter int unsigned MR_VALUE    = 'h0242,
  parameter int unsigned EMR1_VALUE  = 'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calAck,
  output logic              cke,
  output logic [3:0]        cmdCode,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              calReq,
  output logic              initDone
);

  localparam int PWR_CYC  = SHORT_SIM ? SIM_PWR_CYC : 200 * CLK_MHZ;
  localparam int POST_RAW = PWR_CYC / 500;
  localparam int POST_CYC = (POST_RAW < 1) ? 1 : POST_RAW;
  localparam int MAX_A    = (PWR_CYC > T_RFC) ? PWR_CYC : T_RFC;
  localparam int MAX_B    = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int MAX_C    = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int CNT_W    = $clog2(MAX_C + 1);

  seqStrobe_t strb;
  logic       waitZero;
  logic       dllReady;

  ddr2init_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .waitZero (waitZero),
    .dllReady (dllReady),
    .calAck   (calAck),
    .strb     (strb)
  );

  ddr2init_dpath #(
    .PWR_CYC    (PWR_CYC),
    .POST_CYC   (POST_CYC),
    .CNT_W      (CNT_W),
    .T_MRD      (T_MRD),
    .T_RP       (T_RP),
    .T_RFC      (T_RFC),
    .DLL_WAIT   (DLL_WAIT),
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .AP_BIT     (AP_BIT),
    .MR_VALUE   (MR_VALUE),
    .EMR1_VALUE (EMR1_VALUE)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .waitZero (waitZero),
    .dllReady (dllReady),
    .cke      (cke),
    .cmdCode  (cmdCode),
    .bank     (bank),
    .addr     (addr),
    .calReq   (calReq),
    .initDone (initDone)
  );

endmodule

// File: rtl/ddr2init_chk.sv
module ddr2init_chk (
  input logic       clk,
  input logic       rst,
  input logic       calAck,
  input logic       cke,
  input logic [3:0] cmdCode,
  input logic       calReq,
  input logic       initDone
);

  localparam logic [3:0] NOP_CODE = 4'b0111;

  assert_cke_hold_R12: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_cmd_needs_cke_R12: assert property (@(posedge clk) disable iff (rst)
    (cmdCode != NOP_CODE) |-> cke);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (calReq && !calAck) |=> calReq);

  assert_quiet_during_req_R9: assert property (@(posedge clk) disable iff (rst)
    calReq |-> (cmdCode == NOP_CODE));

  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> ($past(calReq) && $past(calAck)));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_req_done_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(calReq && initDone));

endmodule

bind ddr2init_seq ddr2init_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .calAck   (calAck),
  .cke      (cke),
  .cmdCode  (cmdCode),
  .calReq   (calReq),
  .initDone (initDone)
);

// File: tb/test_ddr2init_seq.sv
module test_ddr2init_seq;

  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam logic [3:0] NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic calAck = 1'b0;
  logic cke, calReq, initDone;
  logic [3:0] cmdCode;
  logic [BA_W-1:0] bank;
  logic [ADDR_W-1:0] addr;

  logic fCke, fReq, fDone;
  logic [3:0] fCmd;
  logic [BA_W-1:0] fBank;
  logic [ADDR_W-1:0] fAddr;

  always #4 clk = ~clk; // 125 MHz

  ddr2init_seq #(
    .SHORT_SIM(1'b1), .SIM_PWR_CYC(1500), .T_MRD(2), .T_RP(3), .T_RFC(9),
    .DLL_WAIT(200), .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(10),
    .MR_VALUE('h0242), .EMR1_VALUE('h0005)
  ) i_ddr2init_seq (
    .clk(clk), .rst(rst), .calAck(calAck), .cke(cke), .cmdCode(cmdCode),
    .bank(bank), .addr(addr), .calReq(calReq), .initDone(initDone)
  );

  // Second instance: power-up count below 500 exercises the one-cycle floor.
  ddr2init_seq #(
    .SHORT_SIM(1'b1), .SIM_PWR_CYC(300), .T_MRD(2), .T_RP(3), .T_RFC(9),
    .DLL_WAIT(200), .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(10)
  ) i_ddr2init_seq_floor (
    .clk(clk), .rst(rst), .calAck(1'b0), .cke(fCke), .cmdCode(fCmd),
    .bank(fBank), .addr(fAddr), .calReq(fReq), .initDone(fDone)
  );

  // Expected command list: {cmd[36:33], bank[32:30], addr[29:16], cycle[15:0]}
  localparam logic [36:0] EXPECT [0:10] = '{
    {4'b0010, 3'd0, 14'h0400, 16'd1503},
    {4'b0000, 3'd2, 14'h0000, 16'd1506},
    {4'b0000, 3'd3, 14'h0000, 16'd1508},
    {4'b0000, 3'd1, 14'h0004, 16'd1510},
    {4'b0000, 3'd0, 14'h0342, 16'd1512},
    {4'b0010, 3'd0, 14'h0400, 16'd1514},
    {4'b0001, 3'd0, 14'h0000, 16'd1517},
    {4'b0001, 3'd0, 14'h0000, 16'd1526},
    {4'b0000, 3'd0, 14'h0242, 16'd1535},
    {4'b0000, 3'd1, 14'h0384, 16'd1712},
    {4'b0000, 3'd1, 14'h0004, 16'd1714}
  };

  int cyc = 0;
  int wd = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  int logN;
  logic [3:0] logCmd [0:15];
  logic [BA_W-1:0] logBank [0:15];
  logic [ADDR_W-1:0] logAddr [0:15];
  int logCyc [0:15];
  int ckeCyc, reqCyc, fCkeCyc, fCmdCyc;
  bit nopClean;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      logN = 0; ckeCyc = -1; reqCyc = -1; fCkeCyc = -1; fCmdCyc = -1;
      nopClean = 1'b1;
    end else begin
      if (cke && ckeCyc < 0) ckeCyc = cyc;
      if (calReq && reqCyc < 0) reqCyc = cyc;
      if (fCke && fCkeCyc < 0) fCkeCyc = cyc;
      if (fCmd != NOP && fCmdCyc < 0) fCmdCyc = cyc;
      if (cmdCode != NOP) begin
        if (logN < 16) begin
          logCmd[logN] = cmdCode; logBank[logN] = bank;
          logAddr[logN] = addr; logCyc[logN] = cyc;
        end
        logN++;
      end else if (bank != '0 || addr != '0) begin
        nopClean = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 20000", wd);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(cke == 1'b0 && cmdCode == NOP, "R1", {cke, cmdCode}, {1'b0, NOP});
    check(bank == '0 && addr == '0, "R1", {bank, addr}, 0);
    check(calReq == 1'b0 && initDone == 1'b0, "R1", {calReq, initDone}, 0);
    rst = 1'b0;

    // R11: acknowledge during power-up is ignored
    waitCyc(1000);
    calAck = 1'b1;
    @(negedge clk);
    calAck = 1'b0;
    check(initDone == 1'b0 && cke == 1'b0, "R11", {initDone, cke}, 0);
    // R11: acknowledge in the middle of the command list is ignored
    waitCyc(1520);
    calAck = 1'b1;
    @(negedge clk);
    calAck = 1'b0;
    check(initDone == 1'b0 && calReq == 1'b0, "R11", {initDone, calReq}, 0);

    waitCyc(1720);
    check(ckeCyc == 1500, "R2", ckeCyc, 1500);
    check(logN == 11, "R5", logN, 11);
    for (int i = 0; i < 11; i++) begin
      logic [36:0] e;
      e = EXPECT[i];
      // R4 encodings and R5/R6 contents
      check(logCmd[i] == e[36:33] && logBank[i] == e[32:30] && logAddr[i] == e[29:16],
            (i == 0 || i == 5) ? "R6" : "R5",
            {logCmd[i], logBank[i], logAddr[i]}, e[36:16]);
      // R7 spacing, R8 for the driver-default load
      check(logCyc[i] == int'(e[15:0]), (i == 9) ? "R8" : "R7", logCyc[i], e[15:0]);
    end
    check(nopClean, "R4", nopClean, 1);
    check(reqCyc == 1716, "R9", reqCyc, 1716);
    // R3: post-CKE wait, ordinary and floored
    check(fCkeCyc == 300, "R2", fCkeCyc, 300);
    check(fCmdCyc == 301, "R3", fCmdCyc, 301);

    repeat (5) @(negedge clk);
    check(calReq == 1'b1 && initDone == 1'b0, "R9", {calReq, initDone}, 2'b10);
    calAck = 1'b1;
    @(negedge clk);
    calAck = 1'b0;
    check(initDone == 1'b1 && calReq == 1'b0, "R10", {initDone, calReq}, 2'b10);
    repeat (4) @(negedge clk);
    check(initDone == 1'b1 && cke == 1'b1, "R10", {initDone, cke}, 2'b11);
    check(cmdCode == NOP && logN == 11, "R12", logN, 11);

    // R1: reset after completion
    rst = 1'b1;
    @(negedge clk);
    check(cke == 1'b0 && initDone == 1'b0 && calReq == 1'b0, "R1",
          {cke, initDone, calReq}, 0);
    rst = 1'b0;
    // R1: reset in the middle of the command list
    waitCyc(1520);
    rst = 1'b1;
    @(negedge clk);
    check(cke == 1'b0 && cmdCode == NOP && addr == '0, "R1", {cke, cmdCode}, {1'b0, NOP});
    rst = 1'b0;
    waitCyc(1511);
    check(ckeCyc == 1500, "R1", ckeCyc, 1500);
    check(logN == 4 && logCmd[0] == 4'b0010 && logCyc[0] == 1503, "R1", logN, 4);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule